// File: doc/BRIEF.md
# Speculative Miss Cancellation Tracker

This block keeps a small in-order record of cache-miss loads that have already gone out on the external bus. Each record holds the program-order tag of its load and a cancelled flag. When a mispredicted branch is flushed, every recorded load that is younger than that branch is marked cancelled. The bus request for a marked load cannot be withdrawn, so the load stays in the record until its data returns.

Refill data comes back in issue order, and each return retires the oldest record. A live load's refill goes to both the L1 data cache and the L2 cache. A cancelled load's refill skips L1 and still goes to L2. The L2 strobe is gated by the L2 enable in both cases. If a flush arrives while multiple-outstanding-miss mode is on and loads are still in flight, the block asserts a load/store stall. The stall holds until the last outstanding load has returned. With the mode off, cancellation is purely local and never stalls. No new miss is accepted while the stall is up or while a flush is being applied.

Top module: `spec_miss_tracker`

## Requirements
- R1: After reset the record is empty, `stall` is 0, `req_ready` is 1, and neither fill strobe is asserted, even if `ret_valid` is high.
- R2: A miss is recorded when `req_valid` and `req_ready` are both 1. At most DEPTH loads are held. `req_ready` is 0 while DEPTH loads are outstanding.
- R3: A flush with tag F marks an outstanding load with tag T as cancelled when (T - F) mod 2^TAG_W is nonzero and its top bit is 0. Loads whose tag is equal to F or older than F are left live.
- R4: Returns retire outstanding loads oldest first. A return while nothing is outstanding raises no strobe.
- R5: A return for a live load raises `l1_fill` and raises `l2_fill` equal to `l2_en`, in the same cycle as `ret_valid`.
- R6: A return for a cancelled load keeps `l1_fill` at 0 and raises `l2_fill` equal to `l2_en`.
- R7: With `mom_en` at 0, a flush never raises `stall`.
- R8: With `mom_en` at 1, a flush that arrives while loads are outstanding, and that does not retire the last one in the same cycle, raises `stall` from the next cycle. `stall` stays high until the cycle after the last outstanding load returns. A flush with nothing outstanding leaves `stall` at 0.
- R9: `req_ready` is 0 in any cycle where `stall` or `flush_valid` is 1. A refused request is not recorded.
- R10: When a flush and a return happen in the same cycle, the flush applies to the returning load before the fill strobes are decided.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mom_en | input | 1 | Multiple-outstanding-miss mode enable |
| l2_en | input | 1 | L2 cache enable, gates `l2_fill` |
| req_valid | input | 1 | A miss is being issued on the bus |
| req_tag | input | TAG_W | Program-order tag of the issuing load |
| req_ready | output | 1 | Issue is accepted this cycle |
| flush_valid | input | 1 | Mispredicted-branch flush |
| flush_tag | input | TAG_W | Program-order tag of the flushing branch |
| ret_valid | input | 1 | Refill data for the oldest outstanding load |
| l1_fill | output | 1 | Write the refill into the L1 data cache |
| l2_fill | output | 1 | Write the refill into the L2 cache |
| stall | output | 1 | Hold the load/store pipeline |

## Verification
The bench builds the block with DEPTH=4 and TAG_W=4. With a depth of four, a full record and the refusal it causes are reached after only four issues. With a 16-value tag space, a short run of issues crosses the tag wrap point, so the modular younger-than test is exercised on both sides of zero. Same-cycle flush-and-return and flushes into an empty record are driven directly, because they decide whether the stall should be raised at all.

// File: rtl/spec_miss_tracker.sv
module spec_miss_tracker #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mom_en,
  input  logic             l2_en,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  input  logic             flush_valid,
  input  logic [TAG_W-1:0] flush_tag,
  input  logic             ret_valid,
  output logic             l1_fill,
  output logic             l2_fill,
  output logic             stall
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q, cxl_q, kill;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic             drain_q;

  function automatic logic younger(input logic [TAG_W-1:0] t, input logic [TAG_W-1:0] f);
    logic [TAG_W-1:0] d;
    d = t - f;
    return (d != '0) && !d[TAG_W-1];
  endfunction

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_kill
    assign kill[i] = flush_valid && vld_q[i] && younger(tag_q[i], flush_tag);
  end

  wire have   = cnt_q != '0;
  wire issue  = req_valid && req_ready;
  wire retire = ret_valid && have;

  assign req_ready = !drain_q && !flush_valid && (cnt_q != CW'(DEPTH));
  assign stall     = drain_q;
  assign l1_fill   = retire && !(cxl_q[head_q] || kill[head_q]);
  assign l2_fill   = retire && l2_en;
  assign cnt_nxt   = cnt_q + CW'(issue) - CW'(retire);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      cxl_q   <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      drain_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
    end else begin
      cxl_q <= cxl_q | kill;
      if (retire) begin
        vld_q[head_q] <= 1'b0;
        cxl_q[head_q] <= 1'b0;
        head_q        <= bump(head_q);
      end
      if (issue) begin
        vld_q[tail_q] <= 1'b1;
        cxl_q[tail_q] <= 1'b0;
        tag_q[tail_q] <= req_tag;
        tail_q        <= bump(tail_q);
      end
      cnt_q   <= cnt_nxt;
      drain_q <= (drain_q || (flush_valid && mom_en && have)) && (cnt_nxt != '0);
    end
  end

  // R9
  no_issue_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || flush_valid) |-> !req_ready);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) |-> !req_ready);

  // R4
  no_fill_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have |-> (!l1_fill && !l2_fill));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && cnt_q > CW'(1)) |=> stall);

  // R7
  no_local_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mom_en && !stall) |=> !stall);

  // R5
  l1_implies_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l1_fill && l2_en) |-> l2_fill);
endmodule

// File: tb/test_spec_miss_tracker.sv
module test_spec_miss_tracker;
  logic clk = 1'b0;
  logic rst_n, mom_en, l2_en, req_valid, flush_valid, ret_valid;
  logic [3:0] req_tag, flush_tag;
  logic req_ready, l1_fill, l2_fill, stall;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spec_miss_tracker #(.DEPTH(4), .TAG_W(4)) i_spec_miss_tracker (
    .clk(clk), .rst_n(rst_n), .mom_en(mom_en), .l2_en(l2_en),
    .req_valid(req_valid), .req_tag(req_tag), .req_ready(req_ready),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .ret_valid(ret_valid), .l1_fill(l1_fill), .l2_fill(l2_fill), .stall(stall));

  // {req_v, req_tag, flush_v, flush_tag, ret_v, mom, l2, {ready, stall, l1, l2}}
  localparam logic [16:0] VEC [22] = '{
    {1'b1, 4'd1,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b1, 4'd2,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b1, 4'd5,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b1, 4'd6,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b0000}, // R2 full, refused
    {1'b0, 4'd0,  1'b1, 4'd2,  1'b0, 1'b1, 1'b1, 4'b0000}, // R3 cancels 3 and 5
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b0111}, // R4 tag 1 live
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b0, 4'b0110}, // tag 2 live, L2 off
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b0101}, // R6 tag 3
    {1'b1, 4'd7,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b0101}, // R9 refused, tag 5
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b1000}, // R4 empty return
    {1'b1, 4'd8,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'b1000},
    {1'b1, 4'd9,  1'b0, 4'd0,  1'b0, 1'b0, 1'b1, 4'b1000},
    {1'b0, 4'd0,  1'b1, 4'd8,  1'b0, 1'b0, 1'b1, 4'b0000}, // R7 flush, mode off
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 4'b1011},
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b0, 1'b1, 4'b1001},
    {1'b1, 4'd14, 1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b1, 4'd1,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000},
    {1'b0, 4'd0,  1'b1, 4'd15, 1'b0, 1'b1, 1'b1, 4'b0000}, // R3 wrap compare
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b0111},
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 1'b1, 1'b1, 4'b0101},
    {1'b0, 4'd0,  1'b0, 4'd0,  1'b0, 1'b1, 1'b1, 4'b1000}  // R8 stall released
  };

  task automatic chk(input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [3:0] rt, input logic fv,
                       input logic [3:0] ft, input logic tv, input logic m, input logic l2);
    @(negedge clk);
    req_valid = rv; req_tag = rt; flush_valid = fv; flush_tag = ft;
    ret_valid = tv; mom_en = m; l2_en = l2;
    #1;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_tag = 0; flush_valid = 0; flush_tag = 0;
    ret_valid = 0; mom_en = 1; l2_en = 1;
    repeat (3) @(posedge clk);
    drive(0, 0, 0, 0, 1, 1, 1);
    chk("R1 l1_fill in reset", l1_fill, 1'b0);
    chk("R1 l2_fill in reset", l2_fill, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    drive(0, 0, 0, 0, 1, 1, 1);
    chk("R1 ready after reset", req_ready, 1'b1);
    chk("R1 stall after reset", stall, 1'b0);
    chk("R1 l1_fill after reset", l1_fill, 1'b0);
    chk("R1 l2_fill after reset", l2_fill, 1'b0);

    foreach (VEC[i]) begin
      logic [16:0] v;
      v = VEC[i];
      drive(v[16], v[15:12], v[11], v[10:7], v[6], v[5], v[4]);
      chk($sformatf("R9 req_ready vec %0d", i), req_ready, v[3]);
      chk($sformatf("R8 stall vec %0d", i), stall, v[2]);
      chk($sformatf("R5/R6 l1_fill vec %0d", i), l1_fill, v[1]);
      chk($sformatf("R5/R6 l2_fill vec %0d", i), l2_fill, v[0]);
    end

    // R8: flush into an empty record does not stall
    drive(0, 0, 1, 4'd3, 0, 1, 1);
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R8 flush on empty stall", stall, 1'b0);
    chk("R8 flush on empty ready", req_ready, 1'b1);

    // R10: flush and last return in the same cycle
    drive(1, 4'd4, 0, 0, 0, 1, 1);
    drive(0, 0, 1, 4'd2, 1, 1, 1);
    chk("R10 l1_fill on same-cycle flush", l1_fill, 1'b0);
    chk("R10 l2_fill on same-cycle flush", l2_fill, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 1);
    chk("R10 no stall once drained", stall, 1'b0);

    // R3: older tag is left live
    drive(1, 4'd5, 0, 0, 0, 1, 0);
    drive(0, 0, 1, 4'd9, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 1, 0);
    chk("R3 older load stays live l1", l1_fill, 1'b1);
    chk("R6 l2 gated by enable", l2_fill, 1'b0);
    chk("R8 stall during drain", stall, 1'b1);
    drive(0, 0, 0, 0, 0, 1, 0);
    chk("R8 stall cleared after drain", stall, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule